// File: doc/BRIEF.md
# SD Card Command and Data Register Front-End

This block is the software-visible face of an SD card host path. A processor reaches it through a small word-addressed register bus. One register port accepts command bytes one at a time. The block collects these bytes into a six-byte command frame. When the sixth byte lands, it sends the command index and the 32-bit argument to the card side as a single request. The response bytes that come back are held so that software can read them out one byte at a time through the same port. A second port moves 32-bit data words. Each word is split into four byte transfers toward the card, and four byte transfers from the card are packed into one word. The block also holds plain configuration registers for the clock divider, the channel enables and the start strobes, and presents them as outputs.

The card side uses valid/ready streams. The command request is a one-cycle pulse. The response is a stream of bytes, and its length code is held for the whole response. Data moves as byte streams in each direction, and either side may hold back a transfer. Toward the bus, the block exerts back-pressure by holding `bus_gnt` low. The master keeps `bus_req` and its address, direction and write data stable until it sees `bus_gnt` high at a clock edge. A read returns its data one cycle after the grant, marked by `bus_rvalid`.

Top module: `sdc_reg_frontend`

## Requirements
- R1: After reset the clock divider, enable, pending and start registers read 0, the configuration outputs are 0, no command request is issued and `rsp_overrun` is low.
- R2: The word index is `bus_addr[4:2]` and `bus_addr[1:0]` is ignored. Word 0 is a 32-bit read/write clock divider. Word 1 is the enable register, with bits [3:0] writable and the upper bits reading 0. Word 3 is the start register, with bits [1:0] writable. Words 6 and 7 read 0 and ignore writes. Read data appears with `bus_rvalid` in the cycle after the grant.
- R3: The pending register (word 2) always reads enable bit 3 at bit 3 and enable bit 1 at bit 1, with bits 0 and 2 at 0. Writing to it has no effect.
- R4: Writes to the command register (word 4) take the low byte. On the sixth write, `creq_valid` pulses for exactly one cycle, in the cycle after that write's grant. `creq_cmd` is bits [5:0] of the first byte. `creq_arg` is bytes two to five, with the second byte as the most significant. The sixth byte is discarded.
- R5: From the request pulse until the card's last response beat is accepted, accesses to the command register are not granted. `crsp_ready` is high only within that window and after the pulse.
- R6: Reads of the command register return the response one byte per read. For a card length of 4, the response is six bytes: the command index, the four card bytes in arrival order, then 0x00.
- R7: For a card length of 16, the response is seventeen bytes: 0x3F, followed by the sixteen card bytes in arrival order. For a card length of 0, the card sends one beat whose byte is dropped, and the response is empty.
- R8: A command register read made after every response byte has been read returns 0x00 and raises `rsp_overrun` together with `bus_rvalid`. The read position then returns to the first byte.
- R9: After a frame with command index 0 has been issued, the next command register write is discarded and does not advance the frame position.
- R10: A data register (word 5) write sends four `dtx` beats, most significant byte first. The write is granted only after the fourth beat is accepted.
- R11: A data register read takes four `drx` beats. The first byte goes into bits [31:24]. The read is granted after the fourth beat.
- R12: While `card_present` is low, command reads return 0x000000FF and data reads return 0xFFFFFFFF. Command and data writes are granted at once and change nothing: no request, no `dtx` beat, and no movement of the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_present | input | 1 | High while a card is inserted |
| bus_req | input | 1 | Register access request, held until granted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_gnt | output | 1 | Access accepted at this clock edge |
| bus_rvalid | output | 1 | Read data valid, one cycle after the grant |
| bus_rdata | output | 32 | Read data |
| rsp_overrun | output | 1 | Pulses with a read made past the response end |
| cfg_clkdiv | output | 32 | Clock divider register |
| cfg_enable | output | 4 | Enables: cmd-tx, cmd-rx, dat-tx, dat-rx (bits 0 to 3) |
| cfg_start | output | 2 | Start strobes: cmd-tx (bit 0), dat-rx (bit 1) |
| creq_valid | output | 1 | One-cycle command request pulse |
| creq_cmd | output | 6 | Command index |
| creq_arg | output | 32 | Command argument |
| crsp_valid | input | 1 | Response beat valid |
| crsp_ready | output | 1 | Response beat accepted |
| crsp_len | input | 5 | Response length (0, 4 or 16), held over the response |
| crsp_data | input | 8 | Response byte |
| dtx_valid | output | 1 | Data byte toward the card valid |
| dtx_ready | input | 1 | Card accepts the data byte |
| dtx_data | output | 8 | Data byte toward the card |
| drx_valid | input | 1 | Data byte from the card valid |
| drx_ready | output | 1 | Block accepts the data byte |
| drx_data | input | 8 | Data byte from the card |

## Verification
The assertions check the rules that hold on every cycle. The request is a single-cycle pulse. No command access is granted while the response stream is open. A stalled outbound data byte stays stable. An overrun coincides with a zero read. The pending readback keeps the shape of the enable bits. No request appears while the card is absent. The bench scenarios show what only an end-to-end sequence can. These are the frame decode into index and argument, the reframing of short, long and empty responses, the wrap after an overrun, and the swallowed byte after index 0. They also cover the byte order of packed data words under stalls, and the fact that writes made without a card leave the frame position untouched.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned SDC_W_CLKDIV  = 0;
  localparam int unsigned SDC_W_ENABLE  = 1;
  localparam int unsigned SDC_W_PENDING = 2;
  localparam int unsigned SDC_W_START   = 3;
  localparam int unsigned SDC_W_CMD     = 4;
  localparam int unsigned SDC_W_DATA    = 5;

  localparam int unsigned EN_CMD_RX = 1;
  localparam int unsigned EN_DAT_RX = 3;

  localparam int unsigned RSP_SHORT = 4;
  localparam int unsigned RSP_LONG  = 16;
  localparam logic [7:0]  RSP_LONG_TAG = 8'h3F;
  localparam logic [7:0]  NOCARD_BYTE  = 8'hFF;
endpackage

// File: rtl/sdc_cmd_frame.sv
module sdc_cmd_frame
  import sdc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FRAME_N = 6,
  parameter int CMD_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [BYTE_W-1:0]               wr_byte,
  output logic                            req_valid,
  output logic [CMD_W-1:0]                req_cmd,
  output logic [(FRAME_N-2)*BYTE_W-1:0]   req_arg
);
  localparam int ARG_W = (FRAME_N - 2) * BYTE_W;
  localparam int PTR_W = $clog2(FRAME_N);

  logic [PTR_W-1:0] wptr_q;
  logic             skip_q;
  logic             valid_q;
  logic [CMD_W-1:0] cmd_q;
  logic [ARG_W-1:0] arg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      skip_q  <= 1'b0;
      valid_q <= 1'b0;
      cmd_q   <= '0;
      arg_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (wr_en) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (wptr_q == PTR_W'(0)) begin
          cmd_q  <= wr_byte[CMD_W-1:0];
          wptr_q <= PTR_W'(1);
        end else if (wptr_q == PTR_W'(FRAME_N - 1)) begin
          // last byte carries the check code, which is not forwarded
          wptr_q  <= '0;
          valid_q <= 1'b1;
          skip_q  <= (cmd_q == '0);
        end else begin
          arg_q  <= {arg_q[ARG_W-BYTE_W-1:0], wr_byte};
          wptr_q <= wptr_q + PTR_W'(1);
        end
      end
    end
  end

  assign req_valid = valid_q;
  assign req_cmd   = cmd_q;
  assign req_arg   = arg_q;
endmodule

// File: rtl/sdc_rsp_buf.sv
module sdc_rsp_buf
  import sdc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CMD_W   = 6,
  parameter int LEN_W   = 5,
  parameter int RSP_MAX = RSP_LONG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [CMD_W-1:0]  issue_cmd,
  input  logic              crsp_valid,
  input  logic [LEN_W-1:0]  crsp_len,
  input  logic [BYTE_W-1:0] crsp_data,
  output logic              crsp_ready,
  output logic              busy,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_past
);
  localparam int IDX_W = $clog2(RSP_MAX + 1);

  logic [BYTE_W-1:0] rbuf_q [RSP_MAX];
  logic              busy_q;
  logic [LEN_W-1:0]  bcnt_q;
  logic [IDX_W-1:0]  len_q;
  logic [IDX_W-1:0]  rptr_q;
  logic [IDX_W-1:0]  wr_idx;
  logic              beat;
  logic              last;

  assign wr_idx = IDX_W'(bcnt_q) + IDX_W'(1);
  assign beat   = crsp_valid && busy_q;
  assign last   = (crsp_len == '0) || (bcnt_q == crsp_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      len_q  <= '0;
      rptr_q <= '0;
      for (int i = 0; i < RSP_MAX; i++) rbuf_q[i] <= '0;
    end else begin
      if (issue) begin
        busy_q    <= 1'b1;
        bcnt_q    <= '0;
        rbuf_q[0] <= BYTE_W'(issue_cmd);
      end else if (beat) begin
        if (crsp_len != '0 && wr_idx < IDX_W'(RSP_MAX)) rbuf_q[wr_idx] <= crsp_data;
        bcnt_q <= bcnt_q + LEN_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          bcnt_q <= '0;
          rptr_q <= '0;
          if (crsp_len == LEN_W'(RSP_LONG)) begin
            len_q     <= IDX_W'(RSP_LONG + 1);
            rbuf_q[0] <= RSP_LONG_TAG;
          end else if (crsp_len == LEN_W'(RSP_SHORT)) begin
            len_q                <= IDX_W'(RSP_SHORT + 2);
            rbuf_q[RSP_SHORT + 1] <= '0;
          end else begin
            len_q <= IDX_W'(crsp_len);
          end
        end
      end
      if (rd_en) rptr_q <= rd_past ? '0 : rptr_q + IDX_W'(1);
    end
  end

  assign rd_past    = (rptr_q >= len_q);
  assign rd_byte    = rd_past ? '0 : rbuf_q[rptr_q];
  assign crsp_ready = busy_q;
  assign busy       = busy_q;
endmodule

// File: rtl/sdc_dat_xfer.sv
module sdc_dat_xfer #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic              ack,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              dtx_valid,
  input  logic              dtx_ready,
  output logic [BYTE_W-1:0] dtx_data,
  input  logic              drx_valid,
  output logic              drx_ready,
  input  logic [BYTE_W-1:0] drx_data
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int CNT_W = $clog2(NB + 1);

  logic              active_q;
  logic              dir_wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              more;

  assign more = active_q && (cnt_q != CNT_W'(NB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_wr_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (ack) begin
      active_q <= 1'b0;
    end else if (!active_q && (start_wr || start_rd)) begin
      active_q <= 1'b1;
      dir_wr_q <= start_wr;
      cnt_q    <= '0;
      sh_q     <= start_wr ? wdata : '0;
    end else if (more) begin
      if (dir_wr_q && dtx_ready) begin
        sh_q  <= sh_q << BYTE_W;
        cnt_q <= cnt_q + CNT_W'(1);
      end else if (!dir_wr_q && drx_valid) begin
        sh_q  <= {sh_q[DATA_W-BYTE_W-1:0], drx_data};
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign done      = active_q && !more;
  assign rdata     = sh_q;
  assign dtx_valid = more && dir_wr_q;
  assign dtx_data  = sh_q[DATA_W-1 -: BYTE_W];
  assign drx_ready = more && !dir_wr_q;
endmodule

// File: rtl/sdc_reg_frontend.sv
module sdc_reg_frontend
  import sdc_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int FRAME_N = 6,
  parameter int CMD_W   = 6,
  parameter int LEN_W   = 5,
  parameter int EN_W    = 4,
  parameter int START_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          card_present,
  input  logic                          bus_req,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic                          bus_gnt,
  output logic                          bus_rvalid,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          rsp_overrun,
  output logic [DATA_W-1:0]             cfg_clkdiv,
  output logic [EN_W-1:0]               cfg_enable,
  output logic [START_W-1:0]            cfg_start,
  output logic                          creq_valid,
  output logic [CMD_W-1:0]              creq_cmd,
  output logic [(FRAME_N-2)*BYTE_W-1:0] creq_arg,
  input  logic                          crsp_valid,
  output logic                          crsp_ready,
  input  logic [LEN_W-1:0]              crsp_len,
  input  logic [BYTE_W-1:0]             crsp_data,
  output logic                          dtx_valid,
  input  logic                          dtx_ready,
  output logic [BYTE_W-1:0]             dtx_data,
  input  logic                          drx_valid,
  output logic                          drx_ready,
  input  logic [BYTE_W-1:0]             drx_data
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_addr_lsb;
  logic hit_clk, hit_en, hit_pend, hit_start, hit_cmd, hit_dat;
  logic acc, rsp_busy, cmd_wr_en, cmd_rd_en, dat_done;
  logic [BYTE_W-1:0] rsp_byte;
  logic              rsp_past;
  logic [DATA_W-1:0] dat_word, rd_mux;
  logic [DATA_W-1:0] clkdiv_q, rdata_q;
  logic [EN_W-1:0]   enable_q;
  logic [START_W-1:0] start_q;
  logic              rvalid_q, ovr_q;

  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign hit_clk   = (word == WORD_W'(SDC_W_CLKDIV));
  assign hit_en    = (word == WORD_W'(SDC_W_ENABLE));
  assign hit_pend  = (word == WORD_W'(SDC_W_PENDING));
  assign hit_start = (word == WORD_W'(SDC_W_START));
  assign hit_cmd   = (word == WORD_W'(SDC_W_CMD));
  assign hit_dat   = (word == WORD_W'(SDC_W_DATA));

  always_comb begin
    if (hit_cmd)      bus_gnt = !card_present || (!rsp_busy && !creq_valid);
    else if (hit_dat) bus_gnt = !card_present || dat_done;
    else              bus_gnt = 1'b1;
  end

  assign acc       = bus_req && bus_gnt;
  assign cmd_wr_en = acc && bus_we && hit_cmd && card_present;
  assign cmd_rd_en = acc && !bus_we && hit_cmd && card_present;

  sdc_cmd_frame #(.BYTE_W(BYTE_W), .FRAME_N(FRAME_N), .CMD_W(CMD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .wr_byte(bus_wdata[BYTE_W-1:0]),
    .req_valid(creq_valid), .req_cmd(creq_cmd), .req_arg(creq_arg)
  );

  sdc_rsp_buf #(.BYTE_W(BYTE_W), .CMD_W(CMD_W), .LEN_W(LEN_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .issue(creq_valid), .issue_cmd(creq_cmd),
    .crsp_valid(crsp_valid), .crsp_len(crsp_len), .crsp_data(crsp_data),
    .crsp_ready(crsp_ready), .busy(rsp_busy),
    .rd_en(cmd_rd_en), .rd_byte(rsp_byte), .rd_past(rsp_past)
  );

  sdc_dat_xfer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dat (
    .clk(clk), .rst_n(rst_n),
    .start_wr(bus_req && bus_we && hit_dat && card_present),
    .start_rd(bus_req && !bus_we && hit_dat && card_present),
    .ack(acc && hit_dat), .wdata(bus_wdata), .done(dat_done), .rdata(dat_word),
    .dtx_valid(dtx_valid), .dtx_ready(dtx_ready), .dtx_data(dtx_data),
    .drx_valid(drx_valid), .drx_ready(drx_ready), .drx_data(drx_data)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_clk)   rd_mux = clkdiv_q;
    if (hit_en)    rd_mux = DATA_W'(enable_q);
    if (hit_pend) begin
      rd_mux[EN_CMD_RX] = enable_q[EN_CMD_RX];
      rd_mux[EN_DAT_RX] = enable_q[EN_DAT_RX];
    end
    if (hit_start) rd_mux = DATA_W'(start_q);
    if (hit_cmd)   rd_mux = DATA_W'(card_present ? rsp_byte : NOCARD_BYTE);
    if (hit_dat)   rd_mux = card_present ? dat_word : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkdiv_q <= '0;
      enable_q <= '0;
      start_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      rvalid_q <= acc && !bus_we;
      ovr_q    <= cmd_rd_en && rsp_past;
      if (acc && !bus_we) rdata_q <= rd_mux;
      if (acc && bus_we) begin
        if (hit_clk)   clkdiv_q <= bus_wdata;
        if (hit_en)    enable_q <= bus_wdata[EN_W-1:0];
        if (hit_start) start_q  <= bus_wdata[START_W-1:0];
      end
    end
  end

  assign bus_rvalid  = rvalid_q;
  assign bus_rdata   = rdata_q;
  assign rsp_overrun = ovr_q;
  assign cfg_clkdiv  = clkdiv_q;
  assign cfg_enable  = enable_q;
  assign cfg_start   = start_q;
endmodule

// File: rtl/sdc_reg_frontend_chk.sv
module sdc_reg_frontend_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_present,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rsp_overrun,
  input logic [3:0]        cfg_enable,
  input logic              creq_valid,
  input logic              crsp_ready,
  input logic              dtx_valid,
  input logic              dtx_ready,
  input logic [BYTE_W-1:0] dtx_data
);
  logic [ADDR_W-3:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  // R4
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid |=> !creq_valid);

  // R5
  cmd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crsp_ready && card_present && bus_req && word == 3'd4) |-> !bus_gnt);

  // R10
  dtx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dtx_valid && !dtx_ready && card_present) |=> (dtx_valid && $stable(dtx_data)));

  // R12
  nocard_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_present && $past(!card_present)) |-> !creq_valid);

  // R8
  overrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_overrun |-> (bus_rvalid && bus_rdata == '0));

  // R3
  pending_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_req && bus_gnt && !bus_we && word == 3'd2)) |->
      (bus_rdata[0] == 1'b0 && bus_rdata[2] == 1'b0 &&
       bus_rdata[1] == cfg_enable[1] && bus_rdata[3] == cfg_enable[3]));

  // R2
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && bus_gnt && !bus_we));
endmodule

bind sdc_reg_frontend sdc_reg_frontend_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .card_present(card_present), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid),
  .bus_rdata(bus_rdata), .rsp_overrun(rsp_overrun), .cfg_enable(cfg_enable),
  .creq_valid(creq_valid), .crsp_ready(crsp_ready), .dtx_valid(dtx_valid),
  .dtx_ready(dtx_ready), .dtx_data(dtx_data)
);

// File: tb/sdc_reg_frontend_bench.sv
module sdc_reg_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_present = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_gnt, bus_rvalid, rsp_overrun;
  logic [31:0] bus_rdata, cfg_clkdiv;
  logic [3:0]  cfg_enable;
  logic [1:0]  cfg_start;
  logic        creq_valid;
  logic [5:0]  creq_cmd;
  logic [31:0] creq_arg;
  logic        crsp_valid = 1'b0, crsp_ready;
  logic [4:0]  crsp_len = '0;
  logic [7:0]  crsp_data = '0;
  logic        dtx_valid, dtx_ready = 1'b0;
  logic [7:0]  dtx_data;
  logic        drx_valid = 1'b0, drx_ready;
  logic [7:0]  drx_data = '0;

  sdc_reg_frontend u_sdc_reg_frontend (.*);

  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int resp_delay = 1;
  int nreq = 0;
  int done_cyc = 0, acc_cyc = 0;
  logic [5:0]  got_cmd = '0;
  logic [31:0] got_arg = '0;
  logic [7:0]  tx_log [64];
  int tx_n = 0;
  logic [7:0]  rx_next = 8'h11;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int len_for(input logic [5:0] c);
    if (c == 6'd0) return 0;
    if (c == 6'd2 || c == 6'd9 || c == 6'd10) return 16;
    return 4;
  endfunction

  function automatic logic [7:0] rbyte(input logic [5:0] c, input logic [31:0] a, input int i);
    return 8'(int'(c) * 7 + i * 29 + int'(a[7:0]));
  endfunction

  function automatic logic [7:0] exp_rsp(input logic [5:0] c, input logic [31:0] a, input int idx);
    if (len_for(c) == 16) return (idx == 0) ? 8'h3F : rbyte(c, a, idx - 1);
    if (idx == 0) return {2'b00, c};
    if (idx == 5) return 8'h00;
    return rbyte(c, a, idx - 1);
  endfunction

  task automatic bus_access(input logic we, input logic [4:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output logic ovr);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    #4;
    while (!bus_gnt) begin @(negedge clk); #4; end
    @(negedge clk);
    bus_req = 1'b0;
    acc_cyc = cyc;
    rd = bus_rdata;
    ovr = rsp_overrun;
    if (!we && !bus_rvalid) chk(1'b0, "R2 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] wd);
    logic [31:0] d; logic o;
    bus_access(1'b1, addr, wd, d, o);
  endtask

  task automatic send_cmd(input logic [5:0] c, input logic [31:0] a);
    for (int b = 0; b < 6; b++) begin
      logic [7:0] by;
      if (b == 0) by = {2'b01, c};
      else if (b == 5) by = 8'hA5;
      else by = a[8*(4-b) +: 8];
      wr(5'h10 | 5'(b % 4), {24'h5A5A5A, by});
    end
  endtask

  // card command responder
  initial forever begin
    @(negedge clk);
    if (creq_valid) begin
      int ln, beats;
      got_cmd = creq_cmd; got_arg = creq_arg; nreq++;
      ln = len_for(creq_cmd);
      beats = (ln == 0) ? 1 : ln;
      repeat (resp_delay) @(negedge clk);
      for (int i = 0; i < beats; i++) begin
        crsp_valid = 1'b1; crsp_len = 5'(ln); crsp_data = rbyte(got_cmd, got_arg, i);
        #1;
        while (!crsp_ready) begin @(negedge clk); #1; end
        @(negedge clk);
      end
      crsp_valid = 1'b0;
      done_cyc = cyc;
    end
  end

  // outbound data sink with back-pressure
  initial forever begin
    @(negedge clk);
    dtx_ready = (cyc % 3) != 0;
    if (dtx_valid && dtx_ready) begin tx_log[tx_n % 64] = dtx_data; tx_n++; end
  end

  // inbound data source with gaps
  initial forever begin
    @(negedge clk);
    drx_valid = (cyc % 4) != 1;
    drx_data = rx_next;
    if (drx_valid && drx_ready) rx_next = rx_next + 8'h35;
  end

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d; logic o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(cfg_clkdiv == 0 && cfg_enable == 0 && cfg_start == 0, "R1 cfg", cfg_clkdiv, 0);
    chk(!creq_valid && !rsp_overrun, "R1 quiet", {creq_valid, rsp_overrun}, 0);
    for (int w = 0; w < 4; w++) begin
      bus_access(1'b0, 5'(w * 4), '0, d, o);
      chk(d == 0, "R1 reg reset", d, 0);
    end

    // R2 clock divider, start, unmapped words, low address bits
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h1357_9BDF * (i + 1) ^ (32'(i) << 20);
      wr(5'(i % 4), v);
      bus_access(1'b0, 5'((i + 1) % 4), '0, d, o);
      chk(d == v && cfg_clkdiv == v, "R2 clkdiv", d, v);
      wr(5'h0C | 5'(i % 4), v);
      bus_access(1'b0, 5'h0C, '0, d, o);
      chk(d == 32'(v[1:0]) && cfg_start == v[1:0], "R2 start", d, 32'(v[1:0]));
      wr(5'h18 | 5'(i % 4), ~v);
      bus_access(1'b0, 5'h1C, '0, d, o);
      chk(d == 0, "R2 unmapped read", d, 0);
      bus_access(1'b0, 5'h00, '0, d, o);
      chk(d == v, "R2 unmapped write ignored", d, v);
    end

    // R2 enable and R3 pending, all 16 enable patterns
    for (int i = 0; i < 16; i++) begin
      logic [31:0] pexp;
      wr(5'h04, {28'hABCDEF1, 4'(i)});
      bus_access(1'b0, 5'h05, '0, d, o);
      chk(d == 32'(i) && cfg_enable == 4'(i), "R2 enable", d, 32'(i));
      pexp = 32'(i & 4'b1010);
      bus_access(1'b0, 5'h08, '0, d, o);
      chk(d == pexp, "R3 pending", d, pexp);
      wr(5'h08, 32'hFFFF_FFFF);
      bus_access(1'b0, 5'h0A, '0, d, o);
      chk(d == pexp, "R3 pending write no effect", d, pexp);
    end

    // R4..R8 command frames with short and long responses
    for (int k = 0; k < 8; k++) begin
      logic [5:0] c; logic [31:0] a; int tot, n0;
      c = (k == 0) ? 6'd1 : (k == 1) ? 6'd2 : (k == 2) ? 6'd3 : (k == 3) ? 6'd9 :
          (k == 4) ? 6'd17 : (k == 5) ? 6'd10 : (k == 6) ? 6'd41 : 6'd63;
      a = 32'hC0DE_0000 ^ (32'(k) * 32'h0102_0305);
      resp_delay = 1 + k % 4;
      n0 = nreq;
      send_cmd(c, a);
      bus_access(1'b0, 5'h10, '0, d, o);
      chk(nreq == n0 + 1, "R4 one request", nreq, n0 + 1);
      chk(got_cmd == c, "R4 cmd index", 32'(got_cmd), 32'(c));
      chk(got_arg == a, "R4 argument", got_arg, a);
      chk(acc_cyc > done_cyc, "R5 stall until response", acc_cyc, done_cyc + 1);
      tot = (len_for(c) == 16) ? 17 : 6;
      chk(d == 32'(exp_rsp(c, a, 0)) && !o, (tot == 17) ? "R7 byte0" : "R6 byte0",
          d, 32'(exp_rsp(c, a, 0)));
      for (int j = 1; j < tot; j++) begin
        bus_access(1'b0, 5'h11, '0, d, o);
        chk(d == 32'(exp_rsp(c, a, j)) && !o, (tot == 17) ? "R7 byte" : "R6 byte",
            d, 32'(exp_rsp(c, a, j)));
      end
      bus_access(1'b0, 5'h12, '0, d, o);
      chk(d == 0 && o, "R8 overrun read", {o, d[30:0]}, 32'h8000_0000);
      bus_access(1'b0, 5'h13, '0, d, o);
      chk(d == 32'(exp_rsp(c, a, 0)) && !o, "R8 wrap to first", d, 32'(exp_rsp(c, a, 0)));
    end

    // R9 index 0, then a swallowed byte; R7 empty response
    resp_delay = 2;
    send_cmd(6'd0, 32'h0000_0000);
    bus_access(1'b0, 5'h10, '0, d, o);
    chk(got_cmd == 0, "R9 cmd0 issued", 32'(got_cmd), 0);
    chk(d == 0 && o, "R7 empty response overruns", {o, d[30:0]}, 32'h8000_0000);
    wr(5'h10, 32'h0000_00FF);
    send_cmd(6'd3, 32'h8765_4321);
    bus_access(1'b0, 5'h10, '0, d, o);
    chk(got_cmd == 3 && got_arg == 32'h8765_4321, "R9 frame aligned after skip", got_arg, 32'h8765_4321);

    // R10 data writes under back-pressure
    for (int k = 0; k < 6; k++) begin
      logic [31:0] w; int t0;
      w = 32'hF00D_1234 * (k + 3) + 32'(k);
      t0 = tx_n;
      wr(5'h14 | 5'(k % 4), w);
      chk(tx_n == t0 + 4, "R10 four beats", tx_n - t0, 4);
      for (int b = 0; b < 4; b++)
        chk(tx_log[(t0 + b) % 64] == w[31 - 8*b -: 8], "R10 byte order",
            32'(tx_log[(t0 + b) % 64]), 32'(w[31 - 8*b -: 8]));
    end

    // R11 data reads with gaps
    for (int k = 0; k < 5; k++) begin
      logic [7:0] b0; logic [31:0] e;
      b0 = rx_next;
      e = {b0, b0 + 8'h35, b0 + 8'h6A, b0 + 8'h9F};
      bus_access(1'b0, 5'h14, '0, d, o);
      chk(d == e, "R11 packed word", d, e);
    end

    // R12 no card present
    card_present = 1'b0;
    begin
      int t0, n0;
      t0 = tx_n; n0 = nreq;
      bus_access(1'b0, 5'h10, '0, d, o);
      chk(d == 32'h0000_00FF, "R12 cmd read", d, 32'hFF);
      bus_access(1'b0, 5'h14, '0, d, o);
      chk(d == 32'hFFFF_FFFF, "R12 data read", d, 32'hFFFF_FFFF);
      wr(5'h14, 32'h1234_5678);
      send_cmd(6'd7, 32'h1111_2222);
      wr(5'h10, 32'h0000_0033);
      repeat (4) @(negedge clk);
      chk(tx_n == t0, "R12 no data beats", tx_n, t0);
      chk(nreq == n0, "R12 no request", nreq, n0);
      card_present = 1'b1;
      send_cmd(6'd5, 32'hABCD_0123);
      bus_access(1'b0, 5'h10, '0, d, o);
      chk(nreq == n0 + 1 && got_cmd == 5 && got_arg == 32'hABCD_0123,
          "R12 frame position untouched", got_arg, 32'hABCD_0123);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule